// File: doc/BRIEF.md
# Paged Serial-Presence Memory Controller with Software Write Protection

This block is the byte-level engine behind a 256-byte serial-presence memory held in an internal register array. A serial slave front end, not part of this block, turns bus activity into single-cycle events: a start (or repeated start), a received target-select byte, a received write byte, a request for the next read byte, and a stop. The controller answers each select or write byte with an acknowledge decision one cycle later. It answers each read request with a data byte one cycle later.

Writes are gathered in a one-page buffer. The write pointer advances only within the page. The buffer is committed to the array at stop, after which the device is busy for a fixed number of clock cycles and refuses every select. Reads walk the whole array and wrap from the top address back to zero. Two protect flags, one permanent and one reversible, each guard the lower half of the array. They are queried by the acknowledge decision itself and changed by short command transactions. A high-voltage indication on the lowest address pin arrives as a plain input flag.

Top module: `spd_store_ctrl`

## Requirements
- R1: After reset the pointer is 0x00, every array byte reads 0xFF, both protect flags are clear and `wr_busy` is low.
- R2: A select byte is split as bits 7:4 group code, bits 3:1 device field, bit 0 direction (1 = read). Memory access needs group 0b1010 with a device field equal to `dev_pins` and is acknowledged. Any other unrecognised select is refused, and later write bytes in that transaction get no response.
- R3: In a memory write, the first byte sets the pointer. Each data byte goes to the buffer at the pointer, and then only pointer bits 3:0 increment. More than 16 bytes wrap and overwrite earlier bytes of the same page.
- R4: Buffered data reaches the array only at a stop that ends a write holding at least one buffered byte. A start before the stop discards the buffer.
- R5: A committing stop raises `wr_busy` on the next cycle and holds it for exactly WR_CYCLES cycles. Every select received while busy is refused.
- R6: Each read request returns the byte at the pointer and then increments the whole pointer, wrapping from 0xFF to 0x00.
- R7: A write carrying only an address byte sets the pointer for a following read. A read with no preceding address uses the pointer left by earlier transactions.
- R8: A select with group 0b0110 and direction 1 is a flag query. It is refused when the addressed flag is set and acknowledged when it is clear, and no data follows. The permanent flag is addressed with `hv_a0` low and device field equal to `dev_pins`. The reversible flag is addressed with `hv_a0` high and device field 0b001 or 0b011.
- R9: While either flag is set, a data byte aimed at addresses 0x00 to 0x7F is refused and no write cycle starts. Addresses 0x80 to 0xFF stay writable.
- R10: A permanent-set command is select 0b0110 with `hv_a0` low, device field = `dev_pins`, direction 0, then one dummy address byte and one dummy data byte, all acknowledged. It takes effect at stop, with a write cycle. The command is refused at select once the flag is set, and the flag never clears.
- R11: Reversible commands need `hv_a0` high and direction 0: device field 0b001 sets the flag and 0b011 clears it. Both use the dummy-byte form of R10 and take effect at stop. Both are refused at select while the permanent flag is set.
- R12: `resp_vld` pulses exactly one cycle after each select, and after each write byte that gets a response. `rd_vld` pulses exactly one cycle after each read request served in a read transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_pins | input | 3 | Strapped device address field |
| hv_a0 | input | 1 | High-voltage indication on the lowest address pin |
| ev_start | input | 1 | Start or repeated start seen |
| ev_sel | input | 1 | Select byte received on `bus_byte` |
| ev_byte | input | 1 | Write byte received on `bus_byte` |
| ev_rd | input | 1 | Master requests the next read byte |
| ev_stop | input | 1 | Stop seen |
| bus_byte | input | 8 | Byte accompanying `ev_sel` or `ev_byte` |
| resp_vld | output | 1 | Acknowledge decision valid |
| resp_ack | output | 1 | 1 = acknowledge, 0 = refuse |
| rd_vld | output | 1 | Read byte valid |
| rd_byte | output | 8 | Read data |
| wr_busy | output | 1 | Write cycle in progress |

## Verification
The hardest state to reach is a protected lower half after the permanent flag is set. From then on the permanent flag cannot be undone. Once it is set, the low half of the array can no longer be loaded for other tests. The stimulus therefore first fills all sixteen pages and checks a full wrapping read while nothing is protected. It then cycles the reversible flag through set, blocked write, upper-half write and clear. Only at the end does it set the permanent flag and probe the refusals that follow from it.

// File: rtl/spd_pkg.sv
// Shared types for the paged memory controller.
// Assumes one transaction active at a time, sequenced by the front end.
package spd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MW_ADDR,
        ST_MW_DATA,
        ST_MRD,
        ST_PW_ADDR,
        ST_PW_DATA,
        ST_PW_END
    } spd_state_e;

    typedef enum logic [1:0] {
        PA_NONE,
        PA_SET_PERM,
        PA_SET_REV,
        PA_CLR_REV
    } prot_act_e;

    localparam logic [3:0] GRP_MEM  = 4'b1010;
    localparam logic [3:0] GRP_PROT = 4'b0110;
    localparam logic [2:0] REV_SET_FLD = 3'b001;
    localparam logic [2:0] REV_CLR_FLD = 3'b011;
endpackage

// File: rtl/spd_page_buf.sv
// One-page write buffer: a byte slot and a valid bit per page position.
// Assumes clr and wr_en are never needed in the same cycle; clr wins.
module spd_page_buf #(
    parameter int PAGE_BYTES = 16,
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       wr_en,
    input  logic [PW-1:0]              wr_idx,
    input  logic [7:0]                 wr_data,
    output logic [PAGE_BYTES-1:0][7:0] data_o,
    output logic [PAGE_BYTES-1:0]      mask_o
);
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        // Capture the byte aimed at this slot and remember that it is filled.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                data_o[g] <= 8'h00;
                mask_o[g] <= 1'b0;
            end else if (wr_en && wr_idx == PW'(g)) begin
                data_o[g] <= wr_data;
                mask_o[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spd_protect_flags.sv
// Holds the permanent and reversible protect flags.
// Assumes the caller has already refused illegal commands; apply just executes.
module spd_protect_flags
    import spd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      apply,
    input  prot_act_e act,
    output logic      perm_on,
    output logic      rev_on
);
    // Update the flags when a protect command completes at stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perm_on <= 1'b0;
            rev_on  <= 1'b0;
        end else if (apply) begin
            case (act)
                PA_SET_PERM: perm_on <= 1'b1;
                PA_SET_REV:  rev_on  <= 1'b1;
                PA_CLR_REV:  rev_on  <= 1'b0;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/spd_wcycle_timer.sv
// Counts out the write-cycle time after a commit; busy while nonzero.
// Assumes CYCLES >= 1.
module spd_wcycle_timer #(
    parameter int CYCLES = 250000,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    logic [CW-1:0] cnt;

    // Load on kick, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (kick)       cnt <= CW'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/spd_store_ctrl.sv
// Byte-level controller for a paged serial-presence memory with two
// software protect flags. Consumes decoded bus events, answers with
// registered acknowledge decisions and read bytes one cycle later.
// Assumes the front end never raises two events in one cycle; if it does,
// start > stop > select > byte > read.
module spd_store_ctrl
    import spd_pkg::*;
#(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 250000,
    localparam int AW = $clog2(MEM_BYTES),
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] dev_pins,
    input  logic       hv_a0,
    input  logic       ev_start,
    input  logic       ev_sel,
    input  logic       ev_byte,
    input  logic       ev_rd,
    input  logic       ev_stop,
    input  logic [7:0] bus_byte,
    output logic       resp_vld,
    output logic       resp_ack,
    output logic       rd_vld,
    output logic [7:0] rd_byte,
    output logic       wr_busy
);
    spd_state_e state, sel_next, byte_next;
    prot_act_e  pend_act, sel_act;
    logic [AW-1:0] ptr;
    logic [7:0] mem [MEM_BYTES];
    logic [PAGE_BYTES-1:0][7:0] pbuf;
    logic [PAGE_BYTES-1:0]      pmask;
    logic perm_on, rev_on;
    logic sel_ack, byte_ack, byte_resp, blocked;
    logic do_stop, do_sel, do_byte, rd_fire, buf_we, commit_fire, prot_fire;

    // Event priority qualification.
    assign do_stop = ev_stop && !ev_start;
    assign do_sel  = ev_sel  && !ev_start && !ev_stop;
    assign do_byte = ev_byte && !ev_start && !ev_stop && !ev_sel;
    assign rd_fire = ev_rd && !ev_start && !ev_stop && !ev_sel && !ev_byte
                     && state == ST_MRD;
    assign blocked     = (perm_on || rev_on) && !ptr[AW-1];
    assign buf_we      = do_byte && state == ST_MW_DATA && !blocked;
    assign commit_fire = do_stop && state == ST_MW_DATA && (pmask != '0);
    assign prot_fire   = do_stop && state == ST_PW_END;

    // Decode a select byte into an acknowledge, next state and pending action.
    always_comb begin
        sel_ack  = 1'b0;
        sel_next = ST_IDLE;
        sel_act  = PA_NONE;
        if (!wr_busy) begin
            if (bus_byte[7:4] == GRP_MEM && bus_byte[3:1] == dev_pins) begin
                sel_ack  = 1'b1;
                sel_next = bus_byte[0] ? ST_MRD : ST_MW_ADDR;
            end else if (bus_byte[7:4] == GRP_PROT) begin
                if (!hv_a0 && bus_byte[3:1] == dev_pins) begin
                    if (bus_byte[0]) begin
                        sel_ack = !perm_on;
                    end else if (!perm_on) begin
                        sel_ack  = 1'b1;
                        sel_next = ST_PW_ADDR;
                        sel_act  = PA_SET_PERM;
                    end
                end else if (hv_a0 && (bus_byte[3:1] == REV_SET_FLD ||
                                       bus_byte[3:1] == REV_CLR_FLD)) begin
                    if (bus_byte[0]) begin
                        sel_ack = !rev_on;
                    end else if (!perm_on) begin
                        sel_ack  = 1'b1;
                        sel_next = ST_PW_ADDR;
                        sel_act  = (bus_byte[3:1] == REV_CLR_FLD) ? PA_CLR_REV
                                                                  : PA_SET_REV;
                    end
                end
            end
        end
    end

    // Decide the response to a write byte from the transaction state.
    always_comb begin
        byte_resp = 1'b1;
        byte_ack  = 1'b1;
        byte_next = state;
        case (state)
            ST_MW_ADDR: byte_next = ST_MW_DATA;
            ST_MW_DATA: if (blocked) begin
                            byte_ack  = 1'b0;
                            byte_next = ST_IDLE;
                        end
            ST_PW_ADDR: byte_next = ST_PW_DATA;
            ST_PW_DATA: byte_next = ST_PW_END;
            ST_PW_END:  byte_ack  = 1'b0;
            default: begin
                byte_resp = 1'b0;
                byte_ack  = 1'b0;
            end
        endcase
    end

    // Transaction sequencing, pointer movement and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ptr      <= '0;
            pend_act <= PA_NONE;
            resp_vld <= 1'b0;
            resp_ack <= 1'b0;
            rd_vld   <= 1'b0;
        end else begin
            resp_vld <= 1'b0;
            rd_vld   <= 1'b0;
            if (ev_start || do_stop) begin
                state <= ST_IDLE;
            end else if (do_sel) begin
                resp_vld <= 1'b1;
                resp_ack <= sel_ack;
                state    <= sel_next;
                if (sel_act != PA_NONE) pend_act <= sel_act;
            end else if (do_byte && byte_resp) begin
                resp_vld <= 1'b1;
                resp_ack <= byte_ack;
                state    <= byte_next;
                if (state == ST_MW_ADDR)
                    ptr <= bus_byte[AW-1:0];
                else if (buf_we)
                    ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
            end else if (rd_fire) begin
                rd_vld <= 1'b1;
                ptr    <= ptr + 1'b1;
            end
        end
    end

    // Array storage: erased at reset, page commit at stop, read on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
            rd_byte <= 8'h00;
        end else begin
            if (commit_fire) begin
                for (int i = 0; i < PAGE_BYTES; i++)
                    if (pmask[i]) mem[{ptr[AW-1:PW], PW'(i)}] <= pbuf[i];
            end
            if (rd_fire) rd_byte <= mem[ptr];
        end
    end

    spd_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ev_start || ev_stop),
        .wr_en   (buf_we),
        .wr_idx  (ptr[PW-1:0]),
        .wr_data (bus_byte),
        .data_o  (pbuf),
        .mask_o  (pmask)
    );

    spd_protect_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .apply   (prot_fire),
        .act     (pend_act),
        .perm_on (perm_on),
        .rev_on  (rev_on)
    );

    spd_wcycle_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (commit_fire || prot_fire),
        .busy  (wr_busy)
    );
endmodule

// File: rtl/spd_store_chk.sv
// Temporal checks on the controller's ports and protect state.
// Assumes it is bound into spd_store_ctrl.
module spd_store_chk (
    input logic clk,
    input logic rst_n,
    input logic ev_sel,
    input logic ev_byte,
    input logic ev_rd,
    input logic ev_stop,
    input logic resp_vld,
    input logic resp_ack,
    input logic rd_vld,
    input logic wr_busy,
    input logic perm_on
);
    // R12: a response only follows a select or write byte.
    p_resp_after_evt_r12: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vld |-> $past(ev_sel || ev_byte));

    // R12: read data only follows a read request.
    p_rd_after_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> $past(ev_rd));

    // R5: a select arriving while busy is refused on the next cycle.
    p_busy_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sel && wr_busy) |=> (resp_vld && !resp_ack));

    // R5: a write cycle only begins right after a stop.
    p_busy_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> $past(ev_stop));

    // R10: the permanent flag never returns to clear.
    p_perm_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(perm_on) |-> perm_on);
endmodule

bind spd_store_ctrl spd_store_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_sel   (ev_sel),
    .ev_byte  (ev_byte),
    .ev_rd    (ev_rd),
    .ev_stop  (ev_stop),
    .resp_vld (resp_vld),
    .resp_ack (resp_ack),
    .rd_vld   (rd_vld),
    .wr_busy  (wr_busy),
    .perm_on  (perm_on)
);

// File: tb/spd_store_ctrl_bench.sv
// Self-checking bench: fills the whole array, sweeps reads, then walks the
// protect flags from reversible to permanent.
module spd_store_ctrl_bench;
    localparam int WR = 20;
    localparam logic [2:0] PINS = 3'b101;
    localparam logic [7:0] SEL_MW = {4'b1010, PINS, 1'b0};
    localparam logic [7:0] SEL_MR = {4'b1010, PINS, 1'b1};
    localparam logic [7:0] SEL_PW = {4'b0110, PINS, 1'b0};
    localparam logic [7:0] SEL_PQ = {4'b0110, PINS, 1'b1};
    localparam logic [7:0] SEL_RSET = 8'h62;
    localparam logic [7:0] SEL_RCLR = 8'h66;
    localparam logic [7:0] SEL_RQ   = 8'h63;

    logic clk = 1'b0, rst_n = 1'b0, hv_a0 = 1'b0;
    logic ev_start = 0, ev_sel = 0, ev_byte = 0, ev_rd = 0, ev_stop = 0;
    logic [7:0] bus_byte = 8'h00;
    logic resp_vld, resp_ack, rd_vld, wr_busy;
    logic [7:0] rd_byte;
    logic [7:0] exp_mem [256];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spd_store_ctrl #(.WR_CYCLES(WR)) u_spd_store_ctrl (
        .clk(clk), .rst_n(rst_n), .dev_pins(PINS), .hv_a0(hv_a0),
        .ev_start(ev_start), .ev_sel(ev_sel), .ev_byte(ev_byte),
        .ev_rd(ev_rd), .ev_stop(ev_stop), .bus_byte(bus_byte),
        .resp_vld(resp_vld), .resp_ack(resp_ack), .rd_vld(rd_vld),
        .rd_byte(rd_byte), .wr_busy(wr_busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_ev();
        ev_start = 1; @(negedge clk); ev_start = 0;
    endtask

    task automatic stop_ev();
        ev_stop = 1; @(negedge clk); ev_stop = 0;
    endtask

    task automatic sel_exp(input logic [7:0] b, input bit ack, input string req);
        bus_byte = b; ev_sel = 1; @(negedge clk); ev_sel = 0;
        check(resp_vld && resp_ack == ack, req, {resp_vld, resp_ack}, {1'b1, ack});
    endtask

    task automatic byte_exp(input logic [7:0] b, input bit ack, input string req);
        bus_byte = b; ev_byte = 1; @(negedge clk); ev_byte = 0;
        check(resp_vld && resp_ack == ack, req, {resp_vld, resp_ack}, {1'b1, ack});
    endtask

    task automatic byte_silent(input logic [7:0] b, input string req);
        bus_byte = b; ev_byte = 1; @(negedge clk); ev_byte = 0;
        check(!resp_vld, req, resp_vld, 0);
    endtask

    task automatic rd_exp(input logic [7:0] e, input string req);
        ev_rd = 1; @(negedge clk); ev_rd = 0;
        check(rd_vld && rd_byte == e, req, {rd_vld, rd_byte}, {1'b1, e});
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 1000 && wr_busy; k++) @(negedge clk);
    endtask

    task automatic busy_exp(input bit b, input string req);
        check(wr_busy == b, req, wr_busy, b);
    endtask

    task automatic sel_read_at(input logic [7:0] a, input string req);
        start_ev(); sel_exp(SEL_MW, 1, req); byte_exp(a, 1, req);
        start_ev(); sel_exp(SEL_MR, 1, req);
    endtask

    task automatic prot_cmd(input logic [7:0] s, input string req);
        start_ev(); sel_exp(s, 1, req);
        byte_exp(8'h00, 1, req); byte_exp(8'h00, 1, req);
        stop_ev(); busy_exp(1, req); wait_idle();
    endtask

    // Watchdog: a hang counts as a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] a;
        int n;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);

        // R1: reset state, immediate read from pointer 0x00.
        busy_exp(0, "R1");
        check(!resp_vld && !rd_vld, "R1", {resp_vld, rd_vld}, 0);
        start_ev(); sel_exp(SEL_MR, 1, "R1");
        for (int i = 0; i < 4; i++) rd_exp(8'hFF, "R1");
        stop_ev();
        start_ev(); sel_exp(SEL_PQ, 1, "R1"); stop_ev();
        hv_a0 = 1; start_ev(); sel_exp(SEL_RQ, 1, "R1"); stop_ev(); hv_a0 = 0;

        // R2: wrong device field and wrong group are refused; bytes ignored.
        start_ev(); sel_exp({4'b1010, 3'b100, 1'b0}, 0, "R2");
        byte_silent(8'h12, "R2"); stop_ev(); busy_exp(0, "R2");
        start_ev(); sel_exp({4'b0011, PINS, 1'b0}, 0, "R2"); stop_ev();

        // R3/R5: fill every page; check busy refusal after the first one.
        for (int p = 0; p < 16; p++) begin
            start_ev(); sel_exp(SEL_MW, 1, "R3"); byte_exp(8'(p * 16), 1, "R3");
            for (int i = 0; i < 16; i++) begin
                a = 8'(p * 16 + i);
                exp_mem[a] = 8'(a * 5 + 1);
                byte_exp(exp_mem[a], 1, "R3");
            end
            stop_ev();
            if (p == 0) begin
                busy_exp(1, "R5");
                start_ev(); sel_exp(SEL_MR, 0, "R5"); stop_ev();
                start_ev(); sel_exp(SEL_PQ, 0, "R5"); stop_ev();
            end
            wait_idle();
        end

        // R6: full sweep from 0x00 wrapping past 0xFF.
        sel_read_at(8'h00, "R6");
        for (int k = 0; k < 258; k++) rd_exp(exp_mem[k % 256], "R6");
        stop_ev();

        // R3/R5: 20-byte write wraps inside page 9; busy lasts WR cycles.
        start_ev(); sel_exp(SEL_MW, 1, "R3"); byte_exp(8'h94, 1, "R3");
        for (int i = 0; i < 20; i++) begin
            exp_mem[{4'h9, 4'((4 + i) % 16)}] = 8'(8'h40 + i);
            byte_exp(8'(8'h40 + i), 1, "R3");
        end
        stop_ev();
        n = 0;
        while (wr_busy && n < 1000) begin n++; @(negedge clk); end
        check(n == WR, "R5", n, WR);
        sel_read_at(8'h90, "R3");
        for (int i = 0; i < 18; i++) rd_exp(exp_mem[8'h90 + i], "R3");
        stop_ev();

        // R4: repeated start before stop discards buffered data.
        start_ev(); sel_exp(SEL_MW, 1, "R4"); byte_exp(8'hC0, 1, "R4");
        byte_exp(8'h55, 1, "R4");
        sel_read_at(8'hC0, "R4");
        rd_exp(exp_mem[8'hC0], "R4");
        stop_ev(); busy_exp(0, "R4");

        // R7: pointer after a write, then a data-less write sets it.
        start_ev(); sel_exp(SEL_MW, 1, "R7"); byte_exp(8'hB0, 1, "R7");
        for (int i = 0; i < 5; i++) begin
            exp_mem[8'hB0 + i] = 8'(8'hE0 + i);
            byte_exp(8'(8'hE0 + i), 1, "R7");
        end
        stop_ev(); wait_idle();
        start_ev(); sel_exp(SEL_MR, 1, "R7"); rd_exp(exp_mem[8'hB5], "R7"); stop_ev();
        start_ev(); sel_exp(SEL_MW, 1, "R7"); byte_exp(8'hB3, 1, "R7");
        stop_ev(); busy_exp(0, "R7");
        start_ev(); sel_exp(SEL_MR, 1, "R7");
        rd_exp(exp_mem[8'hB3], "R7"); rd_exp(exp_mem[8'hB4], "R7"); stop_ev();

        // R11/R8: set the reversible flag and query it.
        hv_a0 = 1; prot_cmd(SEL_RSET, "R11");
        start_ev(); sel_exp(SEL_RQ, 0, "R8"); stop_ev();
        hv_a0 = 0;
        start_ev(); sel_exp(SEL_PQ, 1, "R8"); stop_ev();

        // R9: lower half refused, no write cycle; upper half still written.
        start_ev(); sel_exp(SEL_MW, 1, "R9"); byte_exp(8'h10, 1, "R9");
        byte_exp(8'h99, 0, "R9"); byte_silent(8'h98, "R9");
        stop_ev(); busy_exp(0, "R9");
        sel_read_at(8'h10, "R9"); rd_exp(exp_mem[8'h10], "R9"); stop_ev();
        start_ev(); sel_exp(SEL_MW, 1, "R9"); byte_exp(8'h80, 1, "R9");
        exp_mem[8'h80] = 8'h3C; byte_exp(8'h3C, 1, "R9");
        stop_ev(); busy_exp(1, "R9"); wait_idle();
        sel_read_at(8'h80, "R9"); rd_exp(8'h3C, "R9"); stop_ev();

        // R11: clear the reversible flag; lower half writable again.
        hv_a0 = 1; prot_cmd(SEL_RCLR, "R11");
        start_ev(); sel_exp(SEL_RQ, 1, "R11"); stop_ev();
        hv_a0 = 0;
        start_ev(); sel_exp(SEL_MW, 1, "R11"); byte_exp(8'h10, 1, "R11");
        exp_mem[8'h10] = 8'hA7; byte_exp(8'hA7, 1, "R11");
        stop_ev(); wait_idle();
        sel_read_at(8'h10, "R11"); rd_exp(8'hA7, "R11"); stop_ev();

        // R10: set the permanent flag; it blocks, refuses repeats and sticks.
        prot_cmd(SEL_PW, "R10");
        start_ev(); sel_exp(SEL_PQ, 0, "R10"); stop_ev();
        start_ev(); sel_exp(SEL_MW, 1, "R10"); byte_exp(8'h20, 1, "R10");
        byte_exp(8'h01, 0, "R10"); stop_ev(); busy_exp(0, "R10");
        start_ev(); sel_exp(SEL_PW, 0, "R10"); stop_ev();
        hv_a0 = 1;
        start_ev(); sel_exp(SEL_RSET, 0, "R11"); stop_ev();
        start_ev(); sel_exp(SEL_RCLR, 0, "R11"); stop_ev();
        start_ev(); sel_exp(SEL_RQ, 1, "R11"); stop_ev();
        hv_a0 = 0;
        start_ev(); sel_exp(SEL_PQ, 0, "R10"); stop_ev();
        sel_read_at(8'h20, "R10"); rd_exp(exp_mem[8'h20], "R10"); stop_ev();

        // R12: no stray responses once the bus is quiet.
        @(negedge clk);
        check(!resp_vld && !rd_vld, "R12", {resp_vld, rd_vld}, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule